// File: doc/BRIEF.md
# Serial-Programmed Modem Control Register Bank

This block holds six bytes of configuration for a modem device and lets an external processor write and read them over a four-wire serial link: an active-low frame enable, a shift clock, a data input and a data output with a drive enable for the pad. The serial pins are brought into the block's own clock domain through synchronizer chains. Edges of the shift clock are found there, so every register and the data output are clocked by the system clock.

The register contents are split into named control fields for the rest of the device. These are the transmit clock source select, the IF frequency select, the test monitor source select, three 4-bit output gain codes, two 5-bit offset trim codes and the 2-bit local inversion mode. Each byte is stored in full, and its unused bits read back as written. An active-low asynchronous reset clears all six bytes.

A frame is 16 shift clocks long. It holds a direction bit, a 3-bit address, four filler bits and one data byte. Writes take effect at the last rising shift clock edge. Reads drive the addressed byte back during the data half of the frame.

Top module: `sctl_regbank`

## Requirements
- R1: Each of the six registers at addresses 0 to 5 keeps the byte written to it, and a read of that address returns all eight bits unchanged, including bits no field uses.
- R2: While rstN is low, every register is 0x00, every decoded field output is 0 and serOutEn is 0.
- R3: A frame is shifted in MSB first on rising serClk edges while serEnN is low. The order is one direction bit (1 = read, 0 = write), a 3-bit address, four ignored bits, then eight data bits, 16 clocks in all.
- R4: Register 0 drives txClkSel from bit 6, ifSel from bits 4:3 and monSel from bits 1:0. monSel values are 00 envelope, 01 phase detection, 10 delay detection and 11 AFC information.
- R5: Register 1 drives gainI from bits 7:4 and gainQ from bits 3:0. Register 2 drives gainEnv from bits 7:4.
- R6: Register 3 drives offsI from bits 7:3, and register 4 drives offsQ from bits 7:3.
- R7: Register 5 drives invMode from bits 3:2, where 11 means inverted IF and 00 means normal.
- R8: During a read, serOutEn rises on the falling serClk edge that follows the eighth rising edge. serOut then presents the addressed byte MSB first, with a new bit after each later falling edge, so bit 7-k is valid before rising edge 9+k.
- R9: serOutEn is 0 during write frames, during the first eight clocks of a read, and whenever serEnN is high.
- R10: A write to address 6 or 7 changes no register, and a read of address 6 or 7 returns 0x00.
- R11: A frame whose enable is released before the sixteenth rising serClk edge changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| serEnN | input | 1 | Serial frame enable, active low |
| serClk | input | 1 | Serial shift clock |
| serIn | input | 1 | Serial data in |
| serOut | output | 1 | Serial data out |
| serOutEn | output | 1 | Pad drive enable for serOut; pad is high impedance when 0 |
| txClkSel | output | 1 | Transmit clock source select |
| ifSel | output | 2 | IF frequency select |
| monSel | output | 2 | Test monitor source select |
| gainI | output | 4 | I output gain code |
| gainQ | output | 4 | Q output gain code |
| gainEnv | output | 4 | Envelope output gain code |
| offsI | output | 5 | I offset trim code |
| offsQ | output | 5 | Q offset trim code |
| invMode | output | 2 | Local inversion mode |

## Verification
The serial pins pass through two synchronizer stages and one edge register. A write therefore reaches the field outputs about four system clocks after the sixteenth rising serClk edge. A read bit reaches serOut about four system clocks after its falling edge. The bench keeps each serClk half period at eight system clocks and samples serOut at the end of the low half, just before the next rising edge. It checks field outputs and readbacks only after the frame enable has been released and the bus has been idle for eight further cycles. That margin is about twice the worst latency, so no check depends on the exact synchronizer delay.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
  localparam int NUM_REGS   = 6;
  localparam int REG_W      = 8;
  localparam int ADDR_W     = 3;
  localparam int PAD_BITS   = 4;
  localparam int HDR_BITS   = 1 + ADDR_W + PAD_BITS;
  localparam int FRAME_BITS = HDR_BITS + REG_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  // strobes from the frame controller to the register datapath
  typedef struct packed {
    logic              sampleBit;
    logic              bitVal;
    logic              commit;
    logic              loadOut;
    logic              shiftOut;
    logic              dropOut;
    logic [ADDR_W-1:0] addr;
  } strobe_t;
endpackage

// File: rtl/sctl_ctrl.sv
module sctl_ctrl
  import sctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    serEnN,
  input  logic    serClk,
  input  logic    serIn,
  output strobe_t stb
);
  logic [SYNC_STAGES-1:0] clkSync, dinSync, enSync;
  logic clkPrev;
  logic clkS, dinS, enS;
  logic active, rise, fall, inFrame, addrOk;
  logic [CNT_W-1:0]  cnt;
  logic              rwReg;
  logic [ADDR_W-1:0] addrReg;

  // synchronizer chains for the three serial inputs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkSync <= '0;
      dinSync <= '0;
      enSync  <= '1;
      clkPrev <= 1'b0;
    end else begin
      clkSync <= {clkSync[SYNC_STAGES-2:0], serClk};
      dinSync <= {dinSync[SYNC_STAGES-2:0], serIn};
      enSync  <= {enSync[SYNC_STAGES-2:0], serEnN};
      clkPrev <= clkS;
    end
  end

  assign clkS    = clkSync[SYNC_STAGES-1];
  assign dinS    = dinSync[SYNC_STAGES-1];
  assign enS     = enSync[SYNC_STAGES-1];
  assign active  = ~enS;
  assign rise    = clkS & ~clkPrev;
  assign fall    = ~clkS & clkPrev;
  assign inFrame = (cnt < CNT_W'(FRAME_BITS));
  assign addrOk  = (int'(addrReg) < NUM_REGS);

  // bit counter and header capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      rwReg   <= 1'b0;
      addrReg <= '0;
    end else if (!active) begin
      cnt     <= '0;
      rwReg   <= 1'b0;
      addrReg <= '0;
    end else if (rise && inFrame) begin
      cnt <= cnt + 1'b1;
      if (cnt == '0)
        rwReg <= dinS;
      else if (cnt <= CNT_W'(ADDR_W))
        addrReg <= {addrReg[ADDR_W-2:0], dinS};
    end
  end

  always_comb begin
    stb.sampleBit = active & rise & inFrame;
    stb.bitVal    = dinS;
    stb.commit    = active & rise & (cnt == CNT_W'(FRAME_BITS - 1)) & ~rwReg & addrOk;
    stb.loadOut   = active & fall & (cnt == CNT_W'(HDR_BITS)) & rwReg;
    stb.shiftOut  = active & fall & (cnt > CNT_W'(HDR_BITS)) & rwReg;
    stb.dropOut   = ~active;
    stb.addr      = addrReg;
  end
endmodule

// File: rtl/sctl_dpath.sv
module sctl_dpath
  import sctl_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  strobe_t                   stb,
  output logic [NUM_REGS*REG_W-1:0] regFlat,
  output logic                      serOut,
  output logic                      serOutEn
);
  logic [REG_W-2:0] dataSh;
  logic [REG_W-1:0] wrByte, readByte, outSh;
  logic             outEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               dataSh <= '0;
    else if (stb.sampleBit)  dataSh <= {dataSh[REG_W-3:0], stb.bitVal};
  end

  assign wrByte = {dataSh, stb.bitVal};

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [REG_W-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        q <= '0;
      else if (stb.commit && (stb.addr == ADDR_W'(g)))
        q <= wrByte;
    end
    assign regFlat[g*REG_W +: REG_W] = q;
  end

  // addresses beyond the bank read as zero
  always_comb begin
    readByte = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (stb.addr == ADDR_W'(i)) readByte = regFlat[i*REG_W +: REG_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outSh <= '0;
      outEn <= 1'b0;
    end else if (stb.dropOut) begin
      outSh <= '0;
      outEn <= 1'b0;
    end else if (stb.loadOut) begin
      outSh <= readByte;
      outEn <= 1'b1;
    end else if (stb.shiftOut) begin
      outSh <= {outSh[REG_W-2:0], 1'b0};
    end
  end

  assign serOut   = outSh[REG_W-1] & outEn;
  assign serOutEn = outEn;
endmodule

// File: rtl/sctl_decode.sv
module sctl_decode
  import sctl_pkg::*;
(
  input  logic [NUM_REGS*REG_W-1:0] regFlat,
  output logic       txClkSel,
  output logic [1:0] ifSel,
  output logic [1:0] monSel,
  output logic [3:0] gainI,
  output logic [3:0] gainQ,
  output logic [3:0] gainEnv,
  output logic [4:0] offsI,
  output logic [4:0] offsQ,
  output logic [1:0] invMode
);
  localparam int MODE_REG = 0;
  localparam int IQG_REG  = 1;
  localparam int ENVG_REG = 2;
  localparam int IOFS_REG = 3;
  localparam int QOFS_REG = 4;
  localparam int INV_REG  = 5;

  logic [REG_W-1:0] modeB, iqgB, envgB, iofsB, qofsB, invB;
  logic unusedBits;

  assign modeB = regFlat[MODE_REG*REG_W +: REG_W];
  assign iqgB  = regFlat[IQG_REG*REG_W  +: REG_W];
  assign envgB = regFlat[ENVG_REG*REG_W +: REG_W];
  assign iofsB = regFlat[IOFS_REG*REG_W +: REG_W];
  assign qofsB = regFlat[QOFS_REG*REG_W +: REG_W];
  assign invB  = regFlat[INV_REG*REG_W  +: REG_W];

  assign txClkSel = modeB[6];
  assign ifSel    = modeB[4:3];
  assign monSel   = modeB[1:0];
  assign gainI    = iqgB[7:4];
  assign gainQ    = iqgB[3:0];
  assign gainEnv  = envgB[7:4];
  assign offsI    = iofsB[7:3];
  assign offsQ    = qofsB[7:3];
  assign invMode  = invB[3:2];

  // bits kept only for readback
  assign unusedBits = ^{modeB[7], modeB[5], modeB[2], envgB[3:0], iofsB[2:0],
                        qofsB[2:0], invB[7:4], invB[1:0]};
endmodule

// File: rtl/sctl_regbank.sv
module sctl_regbank
  import sctl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       serEnN,
  input  logic       serClk,
  input  logic       serIn,
  output logic       serOut,
  output logic       serOutEn,
  output logic       txClkSel,
  output logic [1:0] ifSel,
  output logic [1:0] monSel,
  output logic [3:0] gainI,
  output logic [3:0] gainQ,
  output logic [3:0] gainEnv,
  output logic [4:0] offsI,
  output logic [4:0] offsQ,
  output logic [1:0] invMode
);
  strobe_t                   stb;
  logic [NUM_REGS*REG_W-1:0] regFlat;

  sctl_ctrl #(.SYNC_STAGES(2)) i_ctrl (
    .clk(clk), .rstN(rstN), .serEnN(serEnN), .serClk(serClk), .serIn(serIn),
    .stb(stb)
  );

  sctl_dpath i_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .regFlat(regFlat),
    .serOut(serOut), .serOutEn(serOutEn)
  );

  sctl_decode i_decode (
    .regFlat(regFlat), .txClkSel(txClkSel), .ifSel(ifSel), .monSel(monSel),
    .gainI(gainI), .gainQ(gainQ), .gainEnv(gainEnv), .offsI(offsI),
    .offsQ(offsQ), .invMode(invMode)
  );
endmodule

// File: rtl/sctl_regbank_chk.sv
module sctl_regbank_chk (
  input logic       clk,
  input logic       rstN,
  input logic       serEnN,
  input logic       serOutEn,
  input logic       txClkSel,
  input logic [1:0] ifSel,
  input logic [1:0] monSel,
  input logic [3:0] gainI,
  input logic [3:0] gainQ,
  input logic [3:0] gainEnv,
  input logic [4:0] offsI,
  input logic [4:0] offsQ,
  input logic [1:0] invMode
);
  logic [29:0] fields;
  assign fields = {txClkSel, ifSel, monSel, gainI, gainQ, gainEnv, offsI, offsQ, invMode};

  // R2
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |-> (fields == '0 && !serOutEn));

  // R9
  idle_no_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (serEnN && $past(serEnN) && $past(serEnN, 2) && $past(serEnN, 3)) |-> !serOutEn);

  // R11
  idle_fields_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (serEnN && $past(serEnN) && $past(serEnN, 2) && $past(serEnN, 3)) |-> $stable(fields));

  // R8
  drive_in_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(serOutEn) |-> !$past(serEnN, 2));
endmodule

bind sctl_regbank sctl_regbank_chk i_chk (
  .clk(clk), .rstN(rstN), .serEnN(serEnN), .serOutEn(serOutEn),
  .txClkSel(txClkSel), .ifSel(ifSel), .monSel(monSel), .gainI(gainI),
  .gainQ(gainQ), .gainEnv(gainEnv), .offsI(offsI), .offsQ(offsQ),
  .invMode(invMode)
);

// File: tb/test_sctl_regbank.sv
module test_sctl_regbank;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCK   = 8;
  localparam int NVEC       = 9;
  // {address, data}
  localparam logic [10:0] VEC [NVEC] = '{
    {3'd0, 8'h5B}, {3'd0, 8'h12}, {3'd1, 8'hA5}, {3'd2, 8'hCF}, {3'd3, 8'hF8},
    {3'd3, 8'h07}, {3'd4, 8'h87}, {3'd5, 8'h0C}, {3'd5, 8'hF3}
  };

  logic clk = 1'b0, rstN = 1'b0, serEnN = 1'b1, serClk = 1'b0, serIn = 1'b0;
  logic serOut, serOutEn, txClkSel;
  logic [1:0] ifSel, monSel, invMode;
  logic [3:0] gainI, gainQ, gainEnv;
  logic [4:0] offsI, offsQ;
  int total = 0, bad = 0;
  logic [7:0] shadow [8];

  sctl_regbank i_sctl_regbank (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // frame: rw, address, data, number of clocks sent; returns read byte and drive flags
  task automatic frame(input bit rw, input logic [2:0] a, input logic [7:0] d,
                       input int nBits, output logic [7:0] rd,
                       output int drvBad, output int drvMiss);
    logic [15:0] bits;
    bits = {rw, a, 4'b1011, d};
    rd = '0; drvBad = 0; drvMiss = 0;
    @(negedge clk) serEnN = 1'b0;
    repeat (HALF_SCK) @(negedge clk);
    for (int i = 0; i < nBits; i++) begin
      serClk = 1'b0;
      serIn  = bits[15-i];
      repeat (HALF_SCK - 1) @(negedge clk);
      if (rw && i >= 8) begin
        rd[15-i] = serOut;
        if (!serOutEn) drvMiss++;
      end else if (serOutEn) drvBad++;
      @(negedge clk) serClk = 1'b1;
      repeat (HALF_SCK - 1) @(negedge clk);
    end
    @(negedge clk) serClk = 1'b0;
    repeat (HALF_SCK) @(negedge clk);
    serEnN = 1'b1;
    repeat (HALF_SCK) @(negedge clk);
    if (serOutEn) drvBad++;
  endtask

  function automatic logic [31:0] expField(input logic [2:0] a, input logic [7:0] d);
    case (a)
      3'd0: return {27'd0, d[6], d[4:3], d[1:0]};
      3'd1: return {24'd0, d[7:4], d[3:0]};
      3'd2: return {28'd0, d[7:4]};
      3'd3: return {27'd0, d[7:3]};
      3'd4: return {27'd0, d[7:3]};
      default: return {30'd0, d[3:2]};
    endcase
  endfunction

  function automatic logic [31:0] obsField(input logic [2:0] a);
    case (a)
      3'd0: return {27'd0, txClkSel, ifSel, monSel};
      3'd1: return {24'd0, gainI, gainQ};
      3'd2: return {28'd0, gainEnv};
      3'd3: return {27'd0, offsI};
      3'd4: return {27'd0, offsQ};
      default: return {30'd0, invMode};
    endcase
  endfunction

  task automatic readAll(input string req);
    logic [7:0] rd; int db, dm;
    for (int a = 0; a < 8; a++) begin
      frame(1'b1, 3'(a), 8'h00, 16, rd, db, dm);
      chk(req, {24'd0, rd}, {24'd0, shadow[a]});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] rd; int db, dm;
    for (int a = 0; a < 8; a++) shadow[a] = 8'h00;
    repeat (3) @(negedge clk);
    // R2: outputs cleared during reset
    chk("R2 fields in reset", {gainI, gainQ, gainEnv, offsI, offsQ, invMode, ifSel, monSel, txClkSel},
        32'd0);
    chk("R2 drive in reset", {31'd0, serOutEn}, 32'd0);
    @(negedge clk) rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R1 R3 R4 R5 R6 R7 R8 R9: table of writes with decode and readback
    for (int v = 0; v < NVEC; v++) begin
      logic [2:0] a; logic [7:0] d;
      a = VEC[v][10:8]; d = VEC[v][7:0];
      frame(1'b0, a, d, 16, rd, db, dm);
      shadow[a] = d;
      chk("R9 no drive on write", db, 0);
      chk("R4-7 field decode", obsField(a), expField(a, d));
      frame(1'b1, a, 8'h00, 16, rd, db, dm);
      chk("R1 R3 readback", {24'd0, rd}, {24'd0, d});
      chk("R8 drive in data phase", dm, 0);
      chk("R9 no drive in header", db, 0);
    end
    readAll("R1 all registers hold");

    // R10: writes beyond the bank ignored, reads return zero
    frame(1'b0, 3'd6, 8'hFF, 16, rd, db, dm);
    frame(1'b0, 3'd7, 8'hA5, 16, rd, db, dm);
    readAll("R10 out-of-range address");

    // R11: aborted frames change nothing
    frame(1'b0, 3'd1, 8'h3C, 12, rd, db, dm);
    chk("R11 abort at 12 clocks", obsField(3'd1), expField(3'd1, shadow[1]));
    frame(1'b0, 3'd3, 8'h50, 15, rd, db, dm);
    chk("R11 abort at 15 clocks", obsField(3'd3), expField(3'd3, shadow[3]));
    readAll("R11 registers after abort");

    // R7: normal mode code 00
    frame(1'b0, 3'd5, 8'hF3, 16, rd, db, dm);
    shadow[5] = 8'hF3;
    chk("R7 normal mode", {30'd0, invMode}, 32'd0);

    // R2: reset mid-run clears everything
    @(negedge clk) rstN = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2 reset mid-run", {gainI, gainQ, gainEnv, offsI, offsQ, invMode, ifSel, monSel, txClkSel},
        32'd0);
    @(negedge clk) rstN = 1'b1;
    for (int a = 0; a < 8; a++) shadow[a] = 8'h00;
    repeat (4) @(negedge clk);
    readAll("R2 readback after reset");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule